// File: doc/BRIEF.md
# Linked Descriptor DMA Channel Engine

This block is one DMA channel that takes its work from descriptors held in memory. After a start pulse it reads an eight-word descriptor from a base address through a dedicated descriptor-read port, checks it, and then moves data unit by unit through a word-wide read/write data port: each beat reads one word from the source and writes the selected byte lanes of it to the target. The unit size, the address increment on each side and the chaining are all taken from the descriptor's command word.

Descriptors chain through an 8-bit offset carried in the top byte of the count word, counted in 16-byte steps from the base given at start. A linked descriptor whose offset is zero jumps back to the base, so a ring of descriptors runs until the channel is stopped. The interrupt is raised only when an unlinked descriptor finishes with its interrupt enable set. Transfers either run freely (auto request) or are paced one unit at a time by a peripheral request/acknowledge pair. A live remaining-unit count is visible on a port while the channel works.

Top module: `ldma_channel`

## Requirements
- R1: After reset `status` equals 32'h4000_0000 (only bit 30, eight-word descriptor mode, set), `irq`, `df_req`, `dp_req` and `periph_ack` are low, and `remaining` is zero.
- R2: A start pulse while idle reads exactly eight words at `desc_base`+0, +4 … +28, in rising order, before any data beat; word 0 is the command, word 1 the source address, word 2 the target address, word 3 holds the unit count in bits 23:0 and the link offset in bits 31:24, word 5 the request type; words 4, 6 and 7 have no effect. The two ports never request in the same cycle.
- R3: The command field in bits 10:8 picks the unit size (0 = 4 bytes, 1 = 1, 2 = 2, 3 = 16, 4 = 32, 5 = 64, 6 = 128); bit 23 enables source increment and bit 22 target increment; units of 4 bytes or more move as whole words, smaller units move only their own byte lanes with byte enables, leaving other target bytes unchanged.
- R4: With an increment bit clear, every beat of that side uses the same word address, so a fixed-address source is read repeatedly.
- R5: Command bit 0 set (link) makes the engine fetch the next descriptor at base + 16 × offset after the current one completes; offset 0 returns to the base and the ring repeats with no interrupt until stopped.
- R6: When a descriptor with bit 0 clear completes, status bit 3 (terminated) is set, bit 0 (enable) clears, and `irq` rises if command bit 1 is set and stays high until the next start; a linked completion never raises `irq`.
- R7: A request type of 8 runs without waiting; any other value makes each unit wait for `periph_req` high and ends each unit with a one-cycle `periph_ack`.
- R8: `remaining` holds the loaded unit count and drops by exactly one per completed unit.
- R9: A source or target address not aligned to the unit size sets status bit 4 (address error), clears enable, raises no interrupt and issues no data beat.
- R10: Size code 7 sets status bit 2 (halt), clears enable and issues no data beat.
- R11: A start pulse while the channel is enabled is ignored.
- R12: `stop` returns the channel to idle with enable clear, no interrupt and no terminated flag.
- R13: A descriptor with a count of zero completes with no data beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a chain at `desc_base` (idle only) |
| desc_base | input | 32 | Byte address of the first descriptor |
| stop | input | 1 | Abandon the current chain |
| df_req | output | 1 | Descriptor word read request |
| df_addr | output | 32 | Descriptor word byte address |
| df_ack | input | 1 | Descriptor read accepted, data valid |
| df_rdata | input | 32 | Descriptor word |
| dp_req | output | 1 | Data beat request |
| dp_we | output | 1 | Data beat is a write |
| dp_addr | output | 32 | Word-aligned data byte address |
| dp_wdata | output | 32 | Write data, lane-steered |
| dp_be | output | 4 | Write byte enables |
| dp_ack | input | 1 | Data beat accepted, read data valid |
| dp_rdata | input | 32 | Read data |
| periph_req | input | 1 | Peripheral ready for one unit |
| periph_ack | output | 1 | One unit finished for the peripheral |
| status | output | 32 | Enable(0), halt(2), terminated(3), address error(4), eight-word mode(30) |
| remaining | output | 24 | Units still to move in the current descriptor |
| irq | output | 1 | Chain-complete interrupt |

## Verification
Flags, `irq` and `remaining` are registered, so they change on the edge that ends the deciding state; the bench reads them on the falling edge after the channel's enable bit has dropped, by which point the final NEXT or CHECK edge has passed. In paced mode `periph_ack` is high for exactly the one cycle of a unit's completion state and `remaining` moves on the following edge, so the bench drops `periph_req` on the falling edge where it sees the acknowledge and samples the count one falling edge later. Memory results are compared only once the run has ended, against a byte model of the whole chain, with random stalls on both read ports so that no check depends on fixed beat latency.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

    // command word bit positions
    localparam int unsigned CMD_LINK = 0;
    localparam int unsigned CMD_TIE  = 1;
    localparam int unsigned CMD_TSZ  = 8;
    localparam int unsigned CMD_DINC = 22;
    localparam int unsigned CMD_SINC = 23;

    // status bit positions
    localparam int unsigned ST_EN   = 0;
    localparam int unsigned ST_HALT = 2;
    localparam int unsigned ST_TERM = 3;
    localparam int unsigned ST_AERR = 4;
    localparam int unsigned ST_DES8 = 30;

    localparam logic [31:0] REQ_AUTO = 32'h8;

    localparam int unsigned DESC_WORDS = 8;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned CNT_W      = 24;
    localparam int unsigned OFF_W      = WORD_W - CNT_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_CHECK,
        PH_WAIT,
        PH_READ,
        PH_WRITE,
        PH_UNIT,
        PH_NEXT
    } phase_e;

endpackage

// File: rtl/ldma_unit_geom.sv
module ldma_unit_geom #(
    parameter int unsigned AW     = 32,
    parameter int unsigned BEAT_W = 6
) (
    input  logic [2:0]        size_code,
    input  logic [AW-1:0]     src_addr,
    input  logic [AW-1:0]     dst_addr,
    input  logic              src_inc,
    input  logic              dst_inc,
    output logic [BEAT_W-1:0] beats,
    output logic [2:0]        lane_bytes,
    output logic [2:0]        src_step,
    output logic [2:0]        dst_step,
    output logic              misaligned,
    output logic              bad_code
);
    logic [7:0]    unit_bytes;
    logic [AW-1:0] mask;

    always_comb begin
        bad_code = 1'b0;
        unique case (size_code)
            3'd0:    unit_bytes = 8'd4;
            3'd1:    unit_bytes = 8'd1;
            3'd2:    unit_bytes = 8'd2;
            3'd3:    unit_bytes = 8'd16;
            3'd4:    unit_bytes = 8'd32;
            3'd5:    unit_bytes = 8'd64;
            3'd6:    unit_bytes = 8'd128;
            default: begin
                unit_bytes = 8'd0;
                bad_code   = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (unit_bytes >= 8'd4) begin
            lane_bytes = 3'd4;
            beats      = BEAT_W'(unit_bytes >> 2);
        end else begin
            lane_bytes = unit_bytes[2:0];
            beats      = BEAT_W'(1);
        end
        src_step   = src_inc ? lane_bytes : 3'd0;
        dst_step   = dst_inc ? lane_bytes : 3'd0;
        mask       = AW'(unit_bytes - 8'd1);
        misaligned = !bad_code && ((|(src_addr & mask)) || (|(dst_addr & mask)));
    end

endmodule

// File: rtl/ldma_lane_steer.sv
module ldma_lane_steer #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0]           rdata,
    input  logic [$clog2(DW/8)-1:0] src_off,
    input  logic [$clog2(DW/8)-1:0] dst_off,
    input  logic [$clog2(DW/8):0]   lane_bytes,
    output logic [DW-1:0]           wdata,
    output logic [DW/8-1:0]         be
);
    localparam int unsigned NB = DW / 8;
    localparam int unsigned OW = $clog2(NB);

    logic [DW-1:0] low_aligned;

    always_comb begin
        low_aligned = rdata >> {src_off, 3'b000};
        wdata       = low_aligned << {dst_off, 3'b000};
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        always_comb begin
            be[i] = ((OW+1)'(i) >= {1'b0, dst_off}) &&
                    ((OW+1)'(i) < ({1'b0, dst_off} + lane_bytes));
        end
    end

endmodule

// File: rtl/ldma_channel.sv
module ldma_channel
    import ldma_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned BEAT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     desc_base,
    input  logic              stop,
    output logic              df_req,
    output logic [AW-1:0]     df_addr,
    input  logic              df_ack,
    input  logic [WORD_W-1:0] df_rdata,
    output logic              dp_req,
    output logic              dp_we,
    output logic [AW-1:0]     dp_addr,
    output logic [WORD_W-1:0] dp_wdata,
    output logic [WORD_W/8-1:0] dp_be,
    input  logic              dp_ack,
    input  logic [WORD_W-1:0] dp_rdata,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic [WORD_W-1:0] status,
    output logic [CNT_W-1:0]  remaining,
    output logic              irq
);
    localparam int unsigned IDX_W = $clog2(DESC_WORDS);

    typedef struct packed {
        phase_e              phase;
        logic [IDX_W-1:0]    widx;
        logic [AW-1:0]       base;
        logic [AW-1:0]       dptr;
        logic [AW-1:0]       src;
        logic [AW-1:0]       dst;
        logic                link;
        logic                tie;
        logic [2:0]          tsz;
        logic                sinc;
        logic                dinc;
        logic [WORD_W-1:0]   drt;
        logic [WORD_W-1:0]   rbuf;
        logic [CNT_W-1:0]    cnt;
        logic [OFF_W-1:0]    off;
        logic [BEAT_W-1:0]   beats_left;
        logic                en;
        logic                halt;
        logic                term;
        logic                aerr;
        logic                irq;
    } ctx_t;

    ctx_t q, d;

    logic [BEAT_W-1:0] g_beats;
    logic [2:0]        g_lane;
    logic [2:0]        g_sstep;
    logic [2:0]        g_dstep;
    logic              g_misaligned;
    logic              g_bad;

    ldma_unit_geom #(.AW(AW), .BEAT_W(BEAT_W)) u_geom (
        .size_code  (q.tsz),
        .src_addr   (q.src),
        .dst_addr   (q.dst),
        .src_inc    (q.sinc),
        .dst_inc    (q.dinc),
        .beats      (g_beats),
        .lane_bytes (g_lane),
        .src_step   (g_sstep),
        .dst_step   (g_dstep),
        .misaligned (g_misaligned),
        .bad_code   (g_bad)
    );

    ldma_lane_steer #(.DW(WORD_W)) u_steer (
        .rdata      (q.rbuf),
        .src_off    (q.src[1:0]),
        .dst_off    (q.dst[1:0]),
        .lane_bytes (g_lane),
        .wdata      (dp_wdata),
        .be         (dp_be)
    );

    always_comb begin
        d          = q;
        df_req     = 1'b0;
        df_addr    = q.dptr + AW'({q.widx, 2'b00});
        dp_req     = 1'b0;
        dp_we      = 1'b0;
        dp_addr    = {q.src[AW-1:2], 2'b00};
        periph_ack = 1'b0;

        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.base  = desc_base;
                    d.dptr  = desc_base;
                    d.widx  = '0;
                    d.en    = 1'b1;
                    d.halt  = 1'b0;
                    d.term  = 1'b0;
                    d.aerr  = 1'b0;
                    d.irq   = 1'b0;
                    d.phase = PH_FETCH;
                end
            end
            PH_FETCH: begin
                df_req = 1'b1;
                if (df_ack) begin
                    unique case (q.widx)
                        IDX_W'(0): begin
                            d.link = df_rdata[CMD_LINK];
                            d.tie  = df_rdata[CMD_TIE];
                            d.tsz  = df_rdata[CMD_TSZ +: 3];
                            d.sinc = df_rdata[CMD_SINC];
                            d.dinc = df_rdata[CMD_DINC];
                        end
                        IDX_W'(1): d.src = AW'(df_rdata);
                        IDX_W'(2): d.dst = AW'(df_rdata);
                        IDX_W'(3): begin
                            d.cnt = df_rdata[CNT_W-1:0];
                            d.off = df_rdata[WORD_W-1:CNT_W];
                        end
                        IDX_W'(5): d.drt = df_rdata;
                        default: ;
                    endcase
                    if (q.widx == IDX_W'(DESC_WORDS - 1)) begin
                        d.phase = PH_CHECK;
                    end else begin
                        d.widx = q.widx + 1'b1;
                    end
                end
            end
            PH_CHECK: begin
                if (g_bad) begin
                    d.halt  = 1'b1;
                    d.en    = 1'b0;
                    d.phase = PH_IDLE;
                end else if (g_misaligned) begin
                    d.aerr  = 1'b1;
                    d.en    = 1'b0;
                    d.phase = PH_IDLE;
                end else if (q.cnt == '0) begin
                    d.phase = PH_NEXT;
                end else begin
                    d.beats_left = g_beats;
                    d.phase      = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (q.drt == REQ_AUTO || periph_req) begin
                    d.phase = PH_READ;
                end
            end
            PH_READ: begin
                dp_req = 1'b1;
                if (dp_ack) begin
                    d.rbuf  = dp_rdata;
                    d.phase = PH_WRITE;
                end
            end
            PH_WRITE: begin
                dp_req  = 1'b1;
                dp_we   = 1'b1;
                dp_addr = {q.dst[AW-1:2], 2'b00};
                if (dp_ack) begin
                    d.src        = q.src + AW'(g_sstep);
                    d.dst        = q.dst + AW'(g_dstep);
                    d.beats_left = q.beats_left - 1'b1;
                    d.phase      = (q.beats_left == BEAT_W'(1)) ? PH_UNIT : PH_READ;
                end
            end
            PH_UNIT: begin
                periph_ack = (q.drt != REQ_AUTO);
                d.cnt      = q.cnt - 1'b1;
                if (q.cnt == CNT_W'(1)) begin
                    d.phase = PH_NEXT;
                end else begin
                    d.beats_left = g_beats;
                    d.phase      = PH_WAIT;
                end
            end
            PH_NEXT: begin
                if (q.link) begin
                    d.dptr  = q.base + AW'({q.off, 4'b0000});
                    d.widx  = '0;
                    d.phase = PH_FETCH;
                end else begin
                    d.term  = 1'b1;
                    d.en    = 1'b0;
                    d.irq   = q.tie;
                    d.phase = PH_IDLE;
                end
            end
            default: d.phase = PH_IDLE;
        endcase

        if (stop && q.phase != PH_IDLE) begin
            d.phase = PH_IDLE;
            d.en    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status          = '0;
        status[ST_EN]   = q.en;
        status[ST_HALT] = q.halt;
        status[ST_TERM] = q.term;
        status[ST_AERR] = q.aerr;
        status[ST_DES8] = 1'b1;
    end

    assign remaining = q.cnt;
    assign irq       = q.irq;

    // R2: descriptor reads and data beats are never requested together
    p_ports_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(df_req && dp_req));

    // R6: the interrupt only appears together with a finished, disabled chain
    p_irq_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[ST_TERM] && !status[ST_EN]));

    // R7: no data beat follows a cycle of waiting without a peripheral request
    p_paced_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_WAIT && q.drt != REQ_AUTO && !periph_req) |=> !dp_req);

    // R8: each completed unit lowers the visible count by exactly one
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_ack && !stop) |=> (remaining == $past(remaining) - 1'b1));

    // R9: an address error never coexists with a data beat
    p_aerr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_AERR] |-> !dp_req);

    // R11: a start while enabled leaves the chain base untouched
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_EN] && start && !stop) |=> $stable(q.base));

endmodule

// File: tb/tb_ldma_channel.sv
module tb_ldma_channel;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] desc_base = '0;
    logic        stop = 1'b0;
    logic        df_req, df_ack;
    logic [31:0] df_addr, df_rdata;
    logic        dp_req, dp_we, dp_ack;
    logic [31:0] dp_addr, dp_wdata, dp_rdata;
    logic [3:0]  dp_be;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic [31:0] status;
    logic [23:0] remaining;
    logic        irq;

    logic [31:0] mem [MEM_WORDS];
    logic [31:0] expm [MEM_WORDS];
    logic        stall_en = 1'b0;
    logic        df_stall = 1'b0;
    logic        dp_stall = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int dp_cnt = 0;
    int fetch_cnt = 0;
    int irq_early = 0;
    int ring_hits = 0;
    int alt_hits = 0;
    logic [31:0] first_fetch = '0;
    logic [31:0] ring_addr = 32'hFFFF_FFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldma_channel dut (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_base(desc_base), .stop(stop),
        .df_req(df_req), .df_addr(df_addr), .df_ack(df_ack), .df_rdata(df_rdata),
        .dp_req(dp_req), .dp_we(dp_we), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
        .dp_be(dp_be), .dp_ack(dp_ack), .dp_rdata(dp_rdata),
        .periph_req(periph_req), .periph_ack(periph_ack),
        .status(status), .remaining(remaining), .irq(irq)
    );

    assign df_ack   = df_req & ~df_stall;
    assign dp_ack   = dp_req & ~dp_stall;
    assign df_rdata = mem[df_addr[13:2]];
    assign dp_rdata = mem[dp_addr[13:2]];

    always @(negedge clk) begin
        df_stall <= stall_en && ($urandom % 3 == 0);
        dp_stall <= stall_en && ($urandom % 3 == 0);
    end

    always @(posedge clk) begin
        if (dp_req && dp_ack && dp_we) begin
            for (int b = 0; b < 4; b++)
                if (dp_be[b]) mem[dp_addr[13:2]][b*8 +: 8] <= dp_wdata[b*8 +: 8];
        end
        if (dp_req) dp_cnt <= dp_cnt + 1;
        if (df_req && df_ack) begin
            if (fetch_cnt == 0) first_fetch <= df_addr;
            fetch_cnt <= fetch_cnt + 1;
            if (df_addr == ring_addr) ring_hits <= ring_hits + 1;
            if (df_addr >= 32'h300 && df_addr < 32'h320) alt_hits <= alt_hits + 1;
        end
        if (irq && status[0]) irq_early <= irq_early + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
        end
    endtask

    task automatic put_desc(input int a, input logic [31:0] cmd, input logic [31:0] src,
                            input logic [31:0] dst, input int cnt, input int off, input logic [31:0] drt);
        mem[a/4 + 0] = cmd;
        mem[a/4 + 1] = src;
        mem[a/4 + 2] = dst;
        mem[a/4 + 3] = {off[7:0], cnt[23:0]};
        mem[a/4 + 4] = $urandom;
        mem[a/4 + 5] = drt;
        mem[a/4 + 6] = $urandom;
        mem[a/4 + 7] = $urandom;
    endtask

    function automatic logic [31:0] mk_cmd(input int code, input bit sinc, input bit dinc,
                                           input bit tie, input bit link);
        logic [31:0] c;
        c = '0;
        c[10:8] = code[2:0];
        c[23] = sinc;
        c[22] = dinc;
        c[1] = tie;
        c[0] = link;
        return c;
    endfunction

    function automatic int unit_size(input int code);
        case (code)
            0: return 4;
            1: return 1;
            2: return 2;
            3: return 16;
            4: return 32;
            5: return 64;
            default: return 128;
        endcase
    endfunction

    task automatic model(input int base);
        int a;
        a = base;
        for (int n = 0; n < 8; n++) begin
            logic [31:0] cmd, w3;
            int size, lane, beats, ss, ds, cnt, src, dst;
            cmd = mem[a/4]; src = mem[a/4 + 1]; dst = mem[a/4 + 2]; w3 = mem[a/4 + 3];
            size = unit_size(int'(cmd[10:8]));
            lane = (size >= 4) ? 4 : size;
            beats = size / lane;
            ss = cmd[23] ? lane : 0;
            ds = cmd[22] ? lane : 0;
            cnt = int'(w3[23:0]);
            for (int u = 0; u < cnt; u++)
                for (int k = 0; k < beats; k++)
                    for (int b = 0; b < lane; b++) begin
                        int sa, da;
                        sa = src + (u*beats + k)*ss + b;
                        da = dst + (u*beats + k)*ds + b;
                        expm[da/4][(da%4)*8 +: 8] = expm[sa/4][(sa%4)*8 +: 8];
                    end
            if (!cmd[0]) break;
            a = base + int'(w3[31:24]) * 16;
        end
    endtask

    task automatic snap();
        for (int i = 0; i < MEM_WORDS; i++) expm[i] = mem[i];
    endtask

    task automatic cmp_mem(input string tag);
        int bad;
        int first;
        bad = 0;
        first = 0;
        for (int i = 32'h400; i < 32'hC00; i++)
            if (mem[i] !== expm[i]) begin
                if (bad == 0) first = i;
                bad++;
            end
        chk(bad == 0, tag, mem[first], expm[first]);
    endtask

    task automatic fill_src();
        for (int i = 32'h400; i < 32'h800; i++) mem[i] = $urandom;
    endtask

    task automatic kick(input int base);
        @(negedge clk);
        dp_cnt = 0;
        fetch_cnt = 0;
        irq_early = 0;
        desc_base = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (!status[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic run(input int base);
        kick(base);
        wait_idle();
        @(negedge clk);
    endtask

    task automatic one_unit();
        periph_req = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (periph_ack) break;
        end
        periph_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(status == 32'h4000_0000, "R1 status", status, 32'h4000_0000);
        chk(!irq && !df_req && !dp_req && !periph_ack, "R1 quiet ports",
            {28'd0, irq, df_req, dp_req, periph_ack}, 32'd0);
        chk(remaining == 24'd0, "R1 remaining", {8'd0, remaining}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R2 / R6: one descriptor per size code, auto request
        for (int code = 0; code < 7; code++) begin
            fill_src();
            put_desc(32'h100, mk_cmd(code, 1, 1, 1, 0), 32'h1000, 32'h2000, 3, 0, 32'h8);
            snap();
            model(32'h100);
            run(32'h100);
            cmp_mem($sformatf("R3 copy size code %0d", code));
            chk(irq && status[3] && !status[0], "R6 irq on terminated chain",
                {irq, status[30:0]}, 32'hC000_0008);
            if (code == 0) begin
                chk(fetch_cnt == 8 && first_fetch == 32'h100, "R2 eight-word fetch from base",
                    fetch_cnt, 8);
            end
        end

        // R4: fixed source address, 16-byte units
        fill_src();
        put_desc(32'h100, mk_cmd(3, 0, 1, 1, 0), 32'h1040, 32'h2000, 2, 0, 32'h8);
        snap();
        model(32'h100);
        run(32'h100);
        cmp_mem("R4 fixed source");

        // R3 / R5 / R6: random chains with stalls
        stall_en = 1'b1;
        for (int it = 0; it < 24; it++) begin
            int nd;
            bit tie;
            nd = 1 + ($urandom % 3);
            tie = $urandom % 2;
            fill_src();
            for (int i = 0; i < nd; i++) begin
                int code, sz;
                bit last;
                last = (i == nd - 1);
                code = $urandom % 7;
                sz = unit_size(code);
                put_desc(32'h100 + i*32'h40,
                         mk_cmd(code, ($urandom % 4) != 0, ($urandom % 8) != 0, last ? tie : 1'b1, !last),
                         32'h1000 + i*32'h400 + ($urandom % 4)*sz,
                         32'h2000 + i*32'h400 + ($urandom % 4)*sz,
                         1 + ($urandom % 4), last ? 0 : (i+1)*4, 32'h8);
            end
            snap();
            model(32'h100);
            run(32'h100);
            cmp_mem($sformatf("R3 random chain %0d", it));
            chk(irq == tie, "R6 irq follows enable bit of last descriptor", {31'd0, irq}, {31'd0, tie});
            chk(irq_early == 0, "R5 no irq while linked", irq_early, 0);
        end
        stall_en = 1'b0;

        // R5 / R12: ring back to base via zero offset, then stop
        put_desc(32'h100, mk_cmd(0, 1, 1, 1, 1), 32'h1000, 32'h2000, 2, 4, 32'h8);
        put_desc(32'h140, mk_cmd(1, 1, 1, 1, 1), 32'h1010, 32'h2010, 3, 0, 32'h8);
        ring_addr = 32'h100;
        ring_hits = 0;
        kick(32'h100);
        for (int i = 0; i < 5000; i++) begin
            if (ring_hits >= 3) break;
            @(negedge clk);
        end
        chk(ring_hits >= 3 && status[0], "R5 ring revisits base", ring_hits, 3);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        @(negedge clk);
        chk(status == 32'h4000_0000 && !irq, "R12 stop leaves idle without irq", status, 32'h4000_0000);
        ring_addr = 32'hFFFF_FFFF;

        // R9: misaligned source
        put_desc(32'h100, mk_cmd(0, 1, 1, 1, 0), 32'h1002, 32'h2000, 2, 0, 32'h8);
        run(32'h100);
        chk(status == 32'h4000_0010, "R9 address error flag", status, 32'h4000_0010);
        chk(dp_cnt == 0 && !irq, "R9 no data beat", dp_cnt, 0);

        // R9: misaligned target for 32-byte units
        put_desc(32'h100, mk_cmd(4, 1, 1, 1, 0), 32'h1000, 32'h2010, 1, 0, 32'h8);
        run(32'h100);
        chk(status[4] && dp_cnt == 0, "R9 target misaligned", status, 32'h4000_0010);

        // R10: size code 7
        put_desc(32'h100, mk_cmd(7, 1, 1, 1, 0), 32'h1000, 32'h2000, 1, 0, 32'h8);
        run(32'h100);
        chk(status == 32'h4000_0004 && dp_cnt == 0, "R10 halt on bad size", status, 32'h4000_0004);

        // R13: zero count
        put_desc(32'h100, mk_cmd(0, 1, 1, 1, 0), 32'h1000, 32'h2000, 0, 0, 32'h8);
        run(32'h100);
        chk(dp_cnt == 0 && irq && status[3], "R13 empty descriptor completes", dp_cnt, 0);

        // R7 / R8 / R11: paced transfer
        fill_src();
        put_desc(32'h100, mk_cmd(0, 1, 1, 1, 0), 32'h1000, 32'h2000, 4, 0, 32'h0);
        put_desc(32'h300, mk_cmd(0, 1, 1, 1, 0), 32'h1000, 32'h2400, 1, 0, 32'h8);
        snap();
        model(32'h100);
        alt_hits = 0;
        kick(32'h100);
        repeat (40) @(negedge clk);
        chk(dp_cnt == 0, "R7 waits for peripheral request", dp_cnt, 0);
        chk(remaining == 24'd4, "R8 loaded count", {8'd0, remaining}, 32'd4);
        desc_base = 32'h300;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        one_unit();
        one_unit();
        chk(remaining == 24'd2, "R8 count after two units", {8'd0, remaining}, 32'd2);
        repeat (20) @(negedge clk);
        chk(remaining == 24'd2 && status[0], "R7 paused between units", {8'd0, remaining}, 32'd2);
        one_unit();
        one_unit();
        wait_idle();
        @(negedge clk);
        cmp_mem("R7 paced copy");
        chk(alt_hits == 0 && irq, "R11 start while running ignored", alt_hits, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule